// File: doc/BRIEF.md
# Trap Entry and Status Stack Controller

This block is the exception front end of a small 32-bit in-order core. Pipeline stages raise synchronous exception requests, each carrying a five-bit reason code, the address of the offending instruction and, where relevant, the bad data or fetch address. External interrupt lines, a return-from-exception strobe and a register move port complete the inputs. The block picks one event per cycle. It records the reason and the restart address, and it pushes a three-deep stack of (user-mode, interrupt-enable) pairs held in the low Status bits. In the following cycle it steers fetch to the fixed handler entry at 0x80000080.

A small state machine has two states. `ST_RUN` is the normal state, and in it events are accepted. `ST_ENTER` lasts one cycle and drives the redirect. Its transitions are: `ST_RUN -> ST_ENTER` when an event is taken, `ST_RUN -> ST_RUN` otherwise, and `ST_ENTER -> ST_RUN` always. Requests that arrive during `ST_ENTER` belong to flushed instructions and are dropped. The block also flags a user-mode memory access that targets the upper, kernel half of the address space. The pipeline then turns that flag into an address-error request.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, Status, Cause, EPC and the bad-address register all read 0 (kernel mode, interrupts off), and `redir_o` is low.
- R2: An event taken at a clock edge raises `redir_o` for exactly the next cycle, with `redir_pc_o` = 0x80000080. After that cycle the block is back in `ST_RUN`.
- R3: On a taken event, EPC holds the address of the winning instruction (or `int_pc_i` for an interrupt), and Cause bits 6:2 hold its reason code (0 interrupt, 1 to 10 the pipeline codes).
- R4: A taken event shifts Status bits 5:0 left by two with zero fill, so bit 1 (user mode, 1 = user) and bit 0 (interrupt enable) become 0.
- R5: `rfe_i` in `ST_RUN` with no event taken shifts Status bits 5:0 right by two and fills bits 5:4 with ones.
- R6: Among simultaneous requests, the lowest slot index (the oldest instruction) wins. Any synchronous request beats a pending interrupt.
- R7: Cause bits 15:10 show `irq_i` delayed by one cycle, and bits 9:8 are software-set. An interrupt is taken when Status bit 0 is 1 and (Cause[15:8] & Status[15:8]) is nonzero. Its code is 0, and it is not taken again while the enable stays 0.
- R8: The bad-address register loads the winning address only for codes 1 to 5. Every other code leaves it unchanged.
- R9: Register selects are 0 Status, 1 Cause, 2 EPC, 3 bad address. Writes to EPC and the bad-address register have no effect. A Cause write changes only bits 9:8. A Status write changes only bits 15:8 and 5:0, and all other Status bits read 0.
- R10: `kviol_o` is high exactly when `mem_valid_i` is high, Status bit 1 is 1, and `mem_addr_i` bit 31 is 1.
- R11: Exception requests, interrupts and `rfe_i` have no effect during the `ST_ENTER` cycle.
- R12: When an event is taken, a same-cycle `rfe_i` and a same-cycle Status write are both discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req_i | input | NSLOT | Exception request per slot, slot 0 oldest |
| exc_code_i | input | NSLOT x 5 | Reason code per slot |
| exc_pc_i | input | NSLOT x DW | Instruction address per slot |
| exc_addr_i | input | NSLOT x DW | Faulting data or fetch address per slot |
| int_pc_i | input | DW | Restart address used when an interrupt is taken |
| irq_i | input | HW_IRQ | External interrupt lines |
| rfe_i | input | 1 | Return-from-exception strobe |
| cp_wr_en_i | input | 1 | Register write enable |
| cp_wr_sel_i | input | 2 | Register write select |
| cp_wr_data_i | input | DW | Register write data |
| cp_rd_sel_i | input | 2 | Register read select |
| cp_rd_data_o | output | DW | Register read data (combinational) |
| mem_valid_i | input | 1 | Memory access present |
| mem_addr_i | input | DW | Memory access address |
| kviol_o | output | 1 | User access to kernel space |
| user_mode_o | output | 1 | Current level is user mode |
| redir_o | output | 1 | Fetch redirect this cycle |
| redir_pc_o | output | DW | Redirect target |

## Verification
The bench sweeps all 64 values of the six-bit stack through a push and a pop, and cycles the reason codes through every value. A shift in the wrong direction or with the wrong fill shows up at once as a wrong Status value, and a wrong code range for the bad-address register leaves a stale or overwritten address. It places a second request and a return strobe in the redirect cycle. A design that accepted them would push twice or overwrite EPC. It also raises an interrupt together with a younger synchronous request. A design that put the interrupt first would report code 0. A held interrupt line must not fire again once the enable has been cleared, or the handler would loop with no end.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int CODE_W = 5;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_ENTER = 1'b1
    } trap_state_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_BADVA  = 2'd3
    } cp_sel_e;

    localparam logic [CODE_W-1:0] EXC_INT   = 5'd0;
    localparam logic [CODE_W-1:0] EXC_MOD   = 5'd1;
    localparam logic [CODE_W-1:0] EXC_ADES  = 5'd5;

    // codes that carry a meaningful faulting address
    function automatic logic keeps_addr(input logic [CODE_W-1:0] code);
        return (code >= EXC_MOD) && (code <= EXC_ADES);
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSLOT-1:0]             req_i,
    input  logic [NSLOT-1:0][CODE_W-1:0] code_i,
    input  logic [NSLOT-1:0][DW-1:0]     pc_i,
    input  logic [NSLOT-1:0][DW-1:0]     addr_i,
    input  logic                         irq_fire_i,
    input  logic [DW-1:0]                irq_pc_i,
    output logic                         take_o,
    output logic [CODE_W-1:0]            code_o,
    output logic [DW-1:0]                pc_o,
    output logic [DW-1:0]                addr_o
);

    logic [NSLOT:0]   older_seen;
    logic [NSLOT-1:0] grant;
    logic             any_req;

    assign older_seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_prio
            assign grant[i]         = req_i[i] & ~older_seen[i];
            assign older_seen[i+1]  = older_seen[i] | req_i[i];
        end
    endgenerate

    assign any_req = older_seen[NSLOT];
    assign take_o  = any_req | irq_fire_i;

    always_comb begin
        code_o = '0;
        pc_o   = '0;
        addr_o = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (grant[i]) begin
                code_o = code_o | code_i[i];
                pc_o   = pc_o | pc_i[i];
                addr_o = addr_o | addr_i[i];
            end
        end
        if (!any_req) begin
            code_o = EXC_INT;
            pc_o   = irq_pc_i;
            addr_o = '0;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_SYNC_BEATS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> ($countones(grant) == 1)); // R6

endmodule

// File: rtl/trap_status.sv
module trap_status #(
    parameter int DW     = 32,
    parameter int IP_W   = 8,
    parameter int LEVELS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  logic                  pop_i,
    input  logic                  wr_en_i,
    input  logic [2*LEVELS-1:0]   wr_stk_i,
    input  logic [IP_W-1:0]       wr_im_i,
    output logic [DW-1:0]         status_o,
    output logic [IP_W-1:0]       im_o,
    output logic                  ie_o,
    output logic                  user_o
);

    localparam int STK_W = 2 * LEVELS;
    localparam int GAP_W = 8 - STK_W;

    logic [STK_W-1:0] stk_q;
    logic [IP_W-1:0]  im_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
            im_q  <= '0;
        end else begin
            if (push_i) begin
                stk_q <= {stk_q[STK_W-3:0], 2'b00};
            end else if (pop_i) begin
                stk_q <= {2'b11, stk_q[STK_W-1:2]};
            end else if (wr_en_i) begin
                stk_q <= wr_stk_i;
            end
            if (wr_en_i && !push_i) begin
                im_q <= wr_im_i;
            end
        end
    end

    assign status_o = DW'({im_q, {GAP_W{1'b0}}, stk_q});
    assign im_o     = im_q;
    assign ie_o     = stk_q[0];
    assign user_o   = stk_q[1];

    AST_STACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (stk_q == {$past(stk_q[STK_W-3:0]), 2'b00})); // R4
    AST_STACK_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (stk_q == {2'b11, $past(stk_q[STK_W-1:2])})); // R5
    AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> $stable(im_q)); // R12

endmodule

// File: rtl/trap_cause.sv
module trap_cause
    import trap_pkg::*;
#(
    parameter int DW     = 32,
    parameter int HW_IRQ = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take_i,
    input  logic [CODE_W-1:0]    code_i,
    input  logic [DW-1:0]        pc_i,
    input  logic [DW-1:0]        addr_i,
    input  logic [HW_IRQ-1:0]    irq_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_sw_i,
    output logic [DW-1:0]        cause_o,
    output logic [HW_IRQ+1:0]    ip_o,
    output logic [DW-1:0]        epc_o,
    output logic [DW-1:0]        badva_o
);

    localparam int IP_W = HW_IRQ + 2;

    logic [CODE_W-1:0] code_q;
    logic [1:0]        sw_q;
    logic [HW_IRQ-1:0] hw_q;
    logic [DW-1:0]     epc_q;
    logic [DW-1:0]     badva_q;
    logic [IP_W-1:0]   ip;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            sw_q    <= '0;
            hw_q    <= '0;
            epc_q   <= '0;
            badva_q <= '0;
        end else begin
            hw_q <= irq_i;
            if (wr_en_i) begin
                sw_q <= wr_sw_i;
            end
            if (take_i) begin
                code_q <= code_i;
                epc_q  <= pc_i;
                if (keeps_addr(code_i)) begin
                    badva_q <= addr_i;
                end
            end
        end
    end

    assign ip      = {hw_q, sw_q};
    assign ip_o    = ip;
    assign cause_o = DW'({ip, 1'b0, code_q, 2'b00});
    assign epc_o   = epc_q;
    assign badva_o = badva_q;

    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(epc_q)); // R9
    AST_BADVA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !keeps_addr(code_i)) |=> $stable(badva_q)); // R8
    AST_HW_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hw_q == $past(irq_i))); // R7

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int          NSLOT  = 2,
    parameter int          DW     = 32,
    parameter int          HW_IRQ = 6,
    parameter logic [31:0] VECTOR = 32'h8000_0080
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSLOT-1:0]             exc_req_i,
    input  logic [NSLOT-1:0][4:0]        exc_code_i,
    input  logic [NSLOT-1:0][DW-1:0]     exc_pc_i,
    input  logic [NSLOT-1:0][DW-1:0]     exc_addr_i,
    input  logic [DW-1:0]                int_pc_i,
    input  logic [HW_IRQ-1:0]            irq_i,
    input  logic                         rfe_i,
    input  logic                         cp_wr_en_i,
    input  logic [1:0]                   cp_wr_sel_i,
    input  logic [DW-1:0]                cp_wr_data_i,
    input  logic [1:0]                   cp_rd_sel_i,
    output logic [DW-1:0]                cp_rd_data_o,
    input  logic                         mem_valid_i,
    input  logic [DW-1:0]                mem_addr_i,
    output logic                         kviol_o,
    output logic                         user_mode_o,
    output logic                         redir_o,
    output logic [DW-1:0]                redir_pc_o
);

    localparam int IP_W     = HW_IRQ + 2;
    localparam int LEVELS   = 3;
    localparam int STK_W    = 2 * LEVELS;
    localparam int KSEG_BIT = DW - 1;

    trap_state_e state_q, state_d;

    logic              in_run;
    logic [NSLOT-1:0]  req_eff;
    logic              irq_fire;
    logic              take;
    logic [CODE_W-1:0] win_code;
    logic [DW-1:0]     win_pc;
    logic [DW-1:0]     win_addr;
    logic              pop;
    logic              wr_status;
    logic              wr_cause;
    logic [DW-1:0]     status;
    logic [IP_W-1:0]   im;
    logic              ie;
    logic              user;
    logic [DW-1:0]     cause;
    logic [IP_W-1:0]   ip;
    logic [DW-1:0]     epc;
    logic [DW-1:0]     badva;
    logic              unused_bits;

    assign unused_bits = ^{cp_wr_data_i[DW-1:8+IP_W], cp_wr_data_i[7:STK_W],
                           mem_addr_i[KSEG_BIT-1:0]};

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = take ? ST_ENTER : ST_RUN;
            ST_ENTER: state_d = ST_RUN;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        redir_o    = 1'b0;
        redir_pc_o = '0;
        unique case (state_q)
            ST_RUN: begin
                redir_o    = 1'b0;
                redir_pc_o = '0;
            end
            ST_ENTER: begin
                redir_o    = 1'b1;
                redir_pc_o = DW'(VECTOR);
            end
        endcase
    end

    assign in_run   = (state_q == ST_RUN);
    assign req_eff  = exc_req_i & {NSLOT{in_run}};
    assign irq_fire = in_run & ie & (|(ip & im));
    assign pop      = in_run & rfe_i & ~take;
    assign wr_status = cp_wr_en_i & (cp_wr_sel_i == SEL_STATUS);
    assign wr_cause  = cp_wr_en_i & (cp_wr_sel_i == SEL_CAUSE);

    trap_arbiter #(.NSLOT(NSLOT), .DW(DW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_eff),
        .code_i     (exc_code_i),
        .pc_i       (exc_pc_i),
        .addr_i     (exc_addr_i),
        .irq_fire_i (irq_fire),
        .irq_pc_i   (int_pc_i),
        .take_o     (take),
        .code_o     (win_code),
        .pc_o       (win_pc),
        .addr_o     (win_addr)
    );

    trap_status #(.DW(DW), .IP_W(IP_W), .LEVELS(LEVELS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (take),
        .pop_i    (pop),
        .wr_en_i  (wr_status),
        .wr_stk_i (cp_wr_data_i[STK_W-1:0]),
        .wr_im_i  (cp_wr_data_i[8 +: IP_W]),
        .status_o (status),
        .im_o     (im),
        .ie_o     (ie),
        .user_o   (user)
    );

    trap_cause #(.DW(DW), .HW_IRQ(HW_IRQ)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .code_i  (win_code),
        .pc_i    (win_pc),
        .addr_i  (win_addr),
        .irq_i   (irq_i),
        .wr_en_i (wr_cause),
        .wr_sw_i (cp_wr_data_i[9:8]),
        .cause_o (cause),
        .ip_o    (ip),
        .epc_o   (epc),
        .badva_o (badva)
    );

    always_comb begin
        cp_rd_data_o = '0;
        unique case (cp_rd_sel_i)
            SEL_STATUS: cp_rd_data_o = status;
            SEL_CAUSE:  cp_rd_data_o = cause;
            SEL_EPC:    cp_rd_data_o = epc;
            SEL_BADVA:  cp_rd_data_o = badva;
        endcase
    end

    assign user_mode_o = user;
    assign kviol_o     = mem_valid_i & user & mem_addr_i[KSEG_BIT];

    AST_TAKE_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redir_o); // R2
    AST_ENTER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER) |=> (state_q == ST_RUN)); // R2
    AST_ENTER_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER) |-> !take); // R11
    AST_HANDLER_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> (!user_mode_o && !status[0])); // R4
    AST_KVIOL_USER: assert property (@(posedge clk) disable iff (!rst_n)
        kviol_o |-> user_mode_o); // R10

endmodule

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;
    localparam int NSLOT = 2;
    localparam int DW    = 32;
    localparam int HWI   = 6;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NSLOT-1:0]         exc_req = '0;
    logic [NSLOT-1:0][4:0]    exc_code = '0;
    logic [NSLOT-1:0][DW-1:0] exc_pc = '0;
    logic [NSLOT-1:0][DW-1:0] exc_addr = '0;
    logic [DW-1:0]            int_pc = '0;
    logic [HWI-1:0]           irq = '0;
    logic                     rfe = 1'b0;
    logic                     wr_en = 1'b0;
    logic [1:0]               wr_sel = '0;
    logic [DW-1:0]            wr_data = '0;
    logic [1:0]               rd_sel = '0;
    logic [DW-1:0]            rd_data;
    logic                     mem_valid = 1'b0;
    logic [DW-1:0]            mem_addr = '0;
    logic                     kviol, user_mode, redir;
    logic [DW-1:0]            redir_pc;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] badv_m = '0;
    logic [DW-1:0] v;

    always #10 clk = ~clk;

    trap_ctrl #(.NSLOT(NSLOT), .DW(DW), .HW_IRQ(HWI)) u_trap_ctrl (
        .clk(clk), .rst_n(rst_n),
        .exc_req_i(exc_req), .exc_code_i(exc_code), .exc_pc_i(exc_pc), .exc_addr_i(exc_addr),
        .int_pc_i(int_pc), .irq_i(irq), .rfe_i(rfe),
        .cp_wr_en_i(wr_en), .cp_wr_sel_i(wr_sel), .cp_wr_data_i(wr_data),
        .cp_rd_sel_i(rd_sel), .cp_rd_data_o(rd_data),
        .mem_valid_i(mem_valid), .mem_addr_i(mem_addr), .kviol_o(kviol),
        .user_mode_o(user_mode), .redir_o(redir), .redir_pc_o(redir_pc)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [DW-1:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic quiet();
        exc_req = '0; rfe = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        rd(2'd0, v); chk("R1 status", v, 32'h0);
        rd(2'd1, v); chk("R1 cause", v, 32'h0);
        rd(2'd2, v); chk("R1 epc", v, 32'h0);
        rd(2'd3, v); chk("R1 badva", v, 32'h0);
        chk("R1 redir", 32'(redir), 32'h0);

        // stack sweep over every six-bit pattern: R3 R4 R5 R8 R9 R2
        for (int p = 0; p < 64; p++) begin
            logic [4:0]  c;
            logic [5:0]  s;
            c = 5'(p % 11);
            s = 6'(p);
            wr(2'd0, 32'hA5A5_FFC0 | 32'(p));
            rd(2'd0, v); chk("R9 status mask", v, 32'h0000_FF00 | 32'(s));
            exc_req[0] = 1'b1; exc_code[0] = c;
            exc_pc[0] = 32'h0040_0000 + 32'(p * 4);
            exc_addr[0] = 32'hB000_0000 + 32'(p * 16);
            if (c >= 5'd1 && c <= 5'd5) badv_m = exc_addr[0];
            cyc();
            quiet();
            chk("R2 redir", 32'(redir), 32'h1);
            chk("R2 vector", redir_pc, 32'h8000_0080);
            rd(2'd0, v); chk("R4 push", v, 32'h0000_FF00 | 32'({s[3:0], 2'b00}));
            rd(2'd1, v); chk("R3 code", v, 32'({c, 2'b00}));
            rd(2'd2, v); chk("R3 epc", v, 32'h0040_0000 + 32'(p * 4));
            rd(2'd3, v); chk("R8 badva", v, badv_m);
            cyc();
            chk("R2 single cycle", 32'(redir), 32'h0);
            rfe = 1'b1;
            cyc();
            rfe = 1'b0;
            rd(2'd0, v); chk("R5 pop", v, 32'h0000_FF00 | 32'({2'b11, s[3:0]}));
        end

        // R9 writes to EPC / bad address / cause code ignored
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hDEAD_BEEF);
        rd(2'd2, v); chk("R9 epc write ignored", v, 32'h0040_0000 + 32'(63 * 4));
        wr(2'd3, 32'h1234_5678);
        rd(2'd3, v); chk("R9 badva write ignored", v, badv_m);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R9 cause sw bits", v, 32'h0000_0300 | 32'({5'(63 % 11), 2'b00}));
        wr(2'd1, 32'h0);

        // R6 oldest slot wins
        exc_req = 2'b11; exc_code[0] = 5'd4; exc_code[1] = 5'd10;
        exc_pc[0] = 32'h0000_1000; exc_pc[1] = 32'h0000_2000;
        exc_addr[0] = 32'h0000_0AA0; exc_addr[1] = 32'h0000_0BB0;
        cyc(); quiet();
        rd(2'd1, v); chk("R6 oldest code", v, 32'd4 << 2);
        rd(2'd2, v); chk("R6 oldest epc", v, 32'h0000_1000);
        rd(2'd3, v); chk("R8 badva load code4", v, 32'h0000_0AA0);
        cyc(); rfe = 1'b1; cyc(); rfe = 1'b0;
        wr(2'd0, 32'h0000_0401);

        // R6 sync request beats enabled interrupt
        irq = 6'b000001;
        cyc();
        exc_req = 2'b10; exc_code[1] = 5'd9; exc_pc[1] = 32'h0000_3000;
        cyc(); quiet();
        rd(2'd1, v); chk("R6 sync over irq", v[6:2], 32'd9);
        rd(2'd2, v); chk("R6 sync epc", v, 32'h0000_3000);
        irq = '0;
        cyc(); rfe = 1'b1; cyc(); rfe = 1'b0;
        wr(2'd0, 32'h0000_0401);

        // R7 interrupt entry and masking
        irq = 6'b000001; int_pc = 32'h0040_1000;
        cyc();
        chk("R7 no take before pending", 32'(redir), 32'h0);
        rd(2'd1, v); chk("R7 pending bit", 32'(v[15:8]), 32'h04);
        cyc();
        chk("R7 irq taken", 32'(redir), 32'h1);
        rd(2'd1, v); chk("R7 irq code", 32'(v[6:2]), 32'h0);
        rd(2'd2, v); chk("R7 irq epc", v, 32'h0040_1000);
        rd(2'd0, v); chk("R7 irq push", v, 32'h0000_0404);
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R7 masked no retrap", 32'(redir), 32'h0);
        end
        irq = '0; rfe = 1'b1;
        cyc(); rfe = 1'b0;
        rd(2'd0, v); chk("R5 pop after irq", v, 32'h0000_0431);
        cyc();
        chk("R7 no irq when line low", 32'(redir), 32'h0);
        wr(2'd0, 32'h0000_002D);

        // R11 redirect cycle ignores requests and rfe
        exc_req = 2'b01; exc_code[0] = 5'd8; exc_pc[0] = 32'h0000_4000;
        cyc();
        exc_code[0] = 5'd9; exc_pc[0] = 32'h0000_5000; rfe = 1'b1;
        cyc(); quiet();
        chk("R11 no second redirect", 32'(redir), 32'h0);
        rd(2'd2, v); chk("R11 epc kept", v, 32'h0000_4000);
        rd(2'd1, v); chk("R11 code kept", 32'(v[6:2]), 32'd8);
        rd(2'd0, v); chk("R11 single push", v, 32'h0000_0034);
        wr(2'd0, 32'h0000_000A);

        // R12 trap beats same-cycle rfe and status write
        exc_req = 2'b01; exc_code[0] = 5'd10; exc_pc[0] = 32'h0000_6000;
        rfe = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0000_FF3F;
        cyc(); quiet();
        rd(2'd0, v); chk("R12 push only", v, 32'h0000_0028);
        rd(2'd2, v); chk("R12 epc", v, 32'h0000_6000);
        cyc();

        // R10 kernel-space check
        wr(2'd0, 32'h0000_0002);
        chk("R10 user mode out", 32'(user_mode), 32'h1);
        mem_valid = 1'b1; mem_addr = 32'h8000_0000; #1;
        chk("R10 user kernel addr", 32'(kviol), 32'h1);
        mem_addr = 32'h7FFF_FFFF; #1;
        chk("R10 user user addr", 32'(kviol), 32'h0);
        mem_addr = 32'hFFFF_FFFC; #1;
        chk("R10 top addr", 32'(kviol), 32'h1);
        mem_valid = 1'b0; #1;
        chk("R10 no access", 32'(kviol), 32'h0);
        wr(2'd0, 32'h0);
        mem_valid = 1'b1; mem_addr = 32'h8000_0000; #1;
        chk("R10 kernel mode", 32'(kviol), 32'h0);
        mem_valid = 1'b0;

        cyc();
        report();
    end
endmodule